// File: doc/BRIEF.md
# Four-Phase Bundled-Data Pipeline Stage Controller

This block is the control half of one bundled-data pipeline stage. It has three handshake partners: an upstream channel that offers a word (request in, acknowledge out), a local datapath that is told to compute and reports when it has finished (start out, done in), and a downstream channel that takes the result (request out, acknowledge in). The data word on either channel is valid only while that channel's request is high. The controller itself moves no data.

All three handshakes follow four-phase, return-to-zero signalling. The controller ties them together in one fixed order of twelve events. On the way up, the upstream request rises, then start, then done, then the downstream request, then the downstream acknowledge, then the upstream acknowledge. On the way down, the same six signals fall in the same order, and only then can the next transfer begin. The controller is a clocked state machine with one state per awaited input event. Its inputs are assumed to be synchronous to its clock already. All three of its handshake outputs come straight from flip-flops.

An input that toggles when the controller is not waiting for it is ignored: the state and the outputs do not change. The toggle sets a sticky protocol-error flag that only reset clears. A transfer that is in progress continues as soon as the input it is waiting for arrives.

Top module: `hs4_stage_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after it is released, `up_ack`, `dp_start`, `dn_req` and `proto_err` are 0 and the controller waits for `up_req`.
- R2: While idle, `up_req` seen high makes `dp_start` rise within two clock cycles.
- R3: While `dp_start` is high and the controller waits for the datapath, `dp_done` seen high makes `dn_req` rise.
- R4: While `dn_req` is high, `dn_ack` seen high makes `up_ack` rise.
- R5: While `up_ack` is high, `up_req` seen low makes `dp_start` fall.
- R6: After `dp_start` has fallen, `dp_done` seen low makes `dn_req` fall.
- R7: After `dn_req` has fallen, `dn_ack` seen low makes `up_ack` fall, and the controller is idle again.
- R8: At most one of the outputs `dp_start`, `dn_req`, `up_ack` changes in any clock cycle, and they change only in the order given by R2 to R7.
- R9: A change on `up_req`, `dp_done` or `dn_ack` that the current step is not waiting for leaves all three handshake outputs unchanged. The sequence then resumes normally when the awaited input arrives.
- R10: Any such unexpected input change sets `proto_err` to 1. It stays at 1 until reset, including across later correct transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream request, data valid while high |
| up_ack | output | 1 | Upstream acknowledge |
| dp_start | output | 1 | Datapath start |
| dp_done | input | 1 | Datapath completion |
| dn_req | output | 1 | Downstream request |
| dn_ack | input | 1 | Downstream acknowledge |
| proto_err | output | 1 | Sticky out-of-order input flag |

## Verification
The hardest condition to reach from the ports is a stray toggle in the middle of a transfer. An example is `dn_ack` pulsing while the controller is still waiting for `dp_done`, and the transfer must then still complete correctly afterwards. The stimulus has a transfer task that can inject such a pulse after `dp_start` rises. The scoreboard expects no output change until `dp_done` is raised, then the normal remaining sequence, while the error flag stays set. A stray `dp_done` while idle, and transfers with zero and longer response gaps, cover the other orderings.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;

  localparam int NUM_WATCH = 3;
  localparam int IDX_REQ   = 0;
  localparam int IDX_DONE  = 1;
  localparam int IDX_ACK   = 2;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_WAIT_DONE_HI = 3'd1,
    ST_WAIT_ACK_HI  = 3'd2,
    ST_WAIT_REQ_LO  = 3'd3,
    ST_WAIT_DONE_LO = 3'd4,
    ST_WAIT_ACK_LO  = 3'd5
  } phase_t;

endpackage

// File: rtl/hs_input_sampler.sv
module hs_input_sampler #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] tog_o
);

  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] old_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q[g] <= 1'b0;
        old_q[g] <= 1'b0;
      end else begin
        cur_q[g] <= raw_i[g];
        old_q[g] <= cur_q[g];
      end
    end
    assign tog_o[g] = cur_q[g] ^ old_q[g];
  end

  assign lvl_o = cur_q;

endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
  import hs_stage_pkg::*;
#(
  parameter int WIDTH = NUM_WATCH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] awaited_o,
  output logic             start_o,
  output logic             oreq_o,
  output logic             iack_o
);

  phase_t st_q, st_d;
  logic   start_q, oreq_q, iack_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:         if (lvl_i[IDX_REQ])   st_d = ST_WAIT_DONE_HI;
      ST_WAIT_DONE_HI: if (lvl_i[IDX_DONE])  st_d = ST_WAIT_ACK_HI;
      ST_WAIT_ACK_HI:  if (lvl_i[IDX_ACK])   st_d = ST_WAIT_REQ_LO;
      ST_WAIT_REQ_LO:  if (!lvl_i[IDX_REQ])  st_d = ST_WAIT_DONE_LO;
      ST_WAIT_DONE_LO: if (!lvl_i[IDX_DONE]) st_d = ST_WAIT_ACK_LO;
      ST_WAIT_ACK_LO:  if (!lvl_i[IDX_ACK])  st_d = ST_IDLE;
      default:                               st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    awaited_o = '0;
    unique case (st_q)
      ST_IDLE, ST_WAIT_REQ_LO:         awaited_o[IDX_REQ]  = 1'b1;
      ST_WAIT_DONE_HI, ST_WAIT_DONE_LO: awaited_o[IDX_DONE] = 1'b1;
      ST_WAIT_ACK_HI, ST_WAIT_ACK_LO:  awaited_o[IDX_ACK]  = 1'b1;
      default:                         awaited_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      oreq_q  <= 1'b0;
      iack_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= (st_d == ST_WAIT_DONE_HI) || (st_d == ST_WAIT_ACK_HI) ||
                 (st_d == ST_WAIT_REQ_LO);
      oreq_q  <= (st_d == ST_WAIT_ACK_HI) || (st_d == ST_WAIT_REQ_LO) ||
                 (st_d == ST_WAIT_DONE_LO);
      iack_q  <= (st_d == ST_WAIT_REQ_LO) || (st_d == ST_WAIT_DONE_LO) ||
                 (st_d == ST_WAIT_ACK_LO);
    end
  end

  assign start_o = start_q;
  assign oreq_o  = oreq_q;
  assign iack_o  = iack_q;

  AST_START_RISE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(start_q) |-> ($past(lvl_i[IDX_REQ]) && !oreq_q && !iack_q)); // R2
  AST_OREQ_RISE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(oreq_q) |-> ($past(lvl_i[IDX_DONE]) && start_q)); // R3
  AST_IACK_RISE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(iack_q) |-> ($past(lvl_i[IDX_ACK]) && oreq_q)); // R4
  AST_START_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(start_q) |-> (!$past(lvl_i[IDX_REQ]) && iack_q)); // R5
  AST_OREQ_FALL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(oreq_q) |-> (!$past(lvl_i[IDX_DONE]) && !start_q)); // R6
  AST_IACK_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(iack_q) |-> (!$past(lvl_i[IDX_ACK]) && !oreq_q)); // R7

endmodule

// File: rtl/hs_error_monitor.sv
module hs_error_monitor #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] tog_i,
  input  logic [WIDTH-1:0] awaited_i,
  output logic             err_o
);

  logic [WIDTH-1:0] stray;
  logic             err_q;

  assign stray = tog_i & ~awaited_i;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | (|stray);
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R10

endmodule

// File: rtl/hs4_stage_ctrl.sv
module hs4_stage_ctrl
  import hs_stage_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic up_req,
  output logic up_ack,
  output logic dp_start,
  input  logic dp_done,
  output logic dn_req,
  input  logic dn_ack,
  output logic proto_err
);

  localparam int W = NUM_WATCH;

  logic [W-1:0] raw, lvl, tog, awaited;
  logic [2:0]   hs_out;

  always_comb begin
    raw           = '0;
    raw[IDX_REQ]  = up_req;
    raw[IDX_DONE] = dp_done;
    raw[IDX_ACK]  = dn_ack;
  end

  hs_input_sampler #(.WIDTH(W)) u_sampler (
    .clk   (clk),
    .rst   (rst),
    .raw_i (raw),
    .lvl_o (lvl),
    .tog_o (tog)
  );

  hs_sequencer #(.WIDTH(W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl),
    .awaited_o (awaited),
    .start_o   (dp_start),
    .oreq_o    (dn_req),
    .iack_o    (up_ack)
  );

  hs_error_monitor #(.WIDTH(W)) u_err (
    .clk       (clk),
    .rst       (rst),
    .tog_i     (tog),
    .awaited_i (awaited),
    .err_o     (proto_err)
  );

  assign hs_out = {up_ack, dn_req, dp_start};

  AST_SINGLE_OUTPUT_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(hs_out ^ $past(hs_out)) <= 1); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (hs_out == 3'b000 && !proto_err)); // R1

endmodule

// File: tb/hs4_stage_ctrl_test.sv
module hs4_stage_ctrl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req = 1'b0, dp_done = 1'b0, dn_ack = 1'b0;
  logic up_ack, dp_start, dn_req, proto_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // expected output events: code = {bit index (0 start,1 dn_req,2 up_ack), new value}
  logic [2:0] exp_q[$];

  always #4 clk = ~clk;

  hs4_stage_ctrl uut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_ack(up_ack),
    .dp_start(dp_start), .dp_done(dp_done), .dn_req(dn_req),
    .dn_ack(dn_ack), .proto_err(proto_err)
  );

  wire [2:0] obs = {up_ack, dn_req, dp_start};

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b001: return "R2";
      3'b011: return "R3";
      3'b101: return "R4";
      3'b000: return "R5";
      3'b010: return "R6";
      3'b100: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: scoreboard compare of every output change
  logic [2:0] prev_obs = 3'b000;
  always @(negedge clk) begin
    if (rst) prev_obs <= obs;
    else begin
      for (int i = 0; i < 3; i++) begin
        if (obs[i] !== prev_obs[i]) begin
          logic [2:0] got;
          got = {i[1:0], obs[i]};
          if (exp_q.size() == 0) begin
            check("R9", {5'b0, got}, 8'hff);
          end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check(tag_of(e), {5'b0, got}, {5'b0, e});
          end
        end
      end
      prev_obs <= obs;
    end
  end

  task automatic wait_obs(input int idx, input logic val);
    int n = 0;
    while (obs[idx] !== val && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (obs[idx] !== val) check(tag_of({idx[1:0], val}), {7'b0, obs[idx]}, {7'b0, val});
    @(negedge clk);
  endtask

  task automatic gap(input int g);
    repeat (g) @(negedge clk);
  endtask

  task automatic transfer(input int g, input bit inject);
    exp_q.push_back(3'b001); up_req = 1'b1; wait_obs(0, 1'b1); gap(g);
    if (inject) begin
      dn_ack = 1'b1; gap(3); dn_ack = 1'b0; gap(6);
      check("R9", {5'b0, obs}, 8'h01);  // stray ack must not move dn_req
      check("R10", {7'b0, proto_err}, 8'h01);
    end
    exp_q.push_back(3'b011); dp_done = 1'b1; wait_obs(1, 1'b1); gap(g);
    exp_q.push_back(3'b101); dn_ack = 1'b1;  wait_obs(2, 1'b1); gap(g);
    exp_q.push_back(3'b000); up_req = 1'b0;  wait_obs(0, 1'b0); gap(g);
    exp_q.push_back(3'b010); dp_done = 1'b0; wait_obs(1, 1'b0); gap(g);
    exp_q.push_back(3'b100); dn_ack = 1'b0;  wait_obs(2, 1'b0); gap(g);
    gap(3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1", {5'b0, obs}, 8'h00);
    check("R1", {7'b0, proto_err}, 8'h00);
    rst = 1'b0;
    gap(3);
    check("R1", {5'b0, obs}, 8'h00);
    check("R1", {7'b0, proto_err}, 8'h00);

    transfer(1, 1'b0);
    transfer(4, 1'b0);
    transfer(0, 1'b0);
    check("R10", {7'b0, proto_err}, 8'h00);

    // stray done while idle
    dp_done = 1'b1; gap(6);
    check("R9", {5'b0, obs}, 8'h00);
    check("R10", {7'b0, proto_err}, 8'h01);
    dp_done = 1'b0; gap(6);
    check("R9", {5'b0, obs}, 8'h00);
    check("R10", {7'b0, proto_err}, 8'h01);
    transfer(2, 1'b0);
    check("R10", {7'b0, proto_err}, 8'h01);

    rst = 1'b1; gap(2); rst = 1'b0; gap(2);
    check("R1", {7'b0, proto_err}, 8'h00);

    // stray downstream ack while waiting for the datapath
    transfer(1, 1'b1);
    check("R10", {7'b0, proto_err}, 8'h01);

    check("R8", {7'b0, (exp_q.size() != 0)}, 8'h00);
    finish_run();
  end

endmodule